// File: doc/BRIEF.md
# Staged Cascade Rejection Classifier

This block decides whether one square detection window of an image holds a face. It walks a fixed chain of boosted stages in order. Inside a stage, each weak classifier builds a two-rectangle Haar-style feature from integral-image lookups: the sum over a light rectangle minus the sum over a dark rectangle. It compares that feature with its own threshold and adds one of two signed votes to the stage total. When the stage's last weak classifier has voted, the total is compared with the stage threshold. A failing stage ends the evaluation at once with a non-face result. A window that clears every stage is reported as a face. The latency therefore depends on the window's content.

A controller pulses `start` with the window origin. The block then drives addresses into three lookup ports that the surrounding system serves combinationally in the same cycle: the integral image, the weak-classifier table and the stage-threshold table. The result comes back as a one-cycle `done` pulse, with `face` qualifying it. Several copies can be placed side by side to score neighbouring windows concurrently.

Top module: `cascade_classifier`

## Requirements
- R1: After synchronous reset, `done` and `face` are low and the block is idle, waiting for `start`.
- R2: A `start` seen while idle latches the origin and begins at stage 0 with weak entry 0. Weak entries are consumed in ascending address order, across stage boundaries. A stage ends at the entry whose `last` bit is set. A weak word is packed MSB first as: last (1 bit); light rectangle x, y, w, h; dark rectangle x, y, w, h (5 bits each); feature threshold (16-bit signed); low vote (12-bit signed); high vote (12-bit signed). The lookup ports are read combinationally in the cycle their address is driven.
- R3: A rectangle at offset (x, y) with size (w, h) is summed from four integral reads at origin-relative points (x, y), (x+w, y), (x, y+h) and (x+w, y+h), with signs +, −, −, +. The integral value at (X, Y) is the sum of all pixels with column < X and row < Y. The feature equals the light sum minus the dark sum.
- R4: A weak classifier contributes its low vote when the feature is strictly below its signed threshold, and its high vote otherwise.
- R5: A stage passes when its signed vote total is greater than or equal to the stage threshold. A failing stage ends the evaluation immediately with `face` low, and no later stage is read.
- R6: `face` is raised only when every one of the NUM_STAGES stages has passed.
- R7: Each weak classifier takes 9 cycles and each stage check takes 1 cycle. `done` is high in the cycle following edge N + Σ(9·W_s + 1), where edge N samples `start` and the sum runs over the stages evaluated.
- R8: `done` is high for exactly one cycle per evaluation. `face` is high only together with `done`.
- R9: A `start` pulse arriving while an evaluation is in progress is ignored. It creates no extra result and does not change the running one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin evaluating a window (ignored while busy) |
| win_x | input | COORD_W | Window origin column |
| win_y | input | COORD_W | Window origin row |
| ii_x | output | COORD_W | Integral-image read column |
| ii_y | output | COORD_W | Integral-image read row |
| ii_data | input | II_W | Integral-image value at (ii_x, ii_y) |
| weak_addr | output | FEAT_AW | Weak-classifier table address |
| weak_word | input | WEAK_BITS | Weak-classifier entry at weak_addr |
| stage_addr | output | $clog2(NUM_STAGES) | Stage-threshold table address |
| stage_thr | input | SUM_W | Signed stage threshold at stage_addr |
| done | output | 1 | One-cycle result pulse |
| face | output | 1 | Window classified as a face, valid with done |

## Verification
Every result is due at a cycle fixed by the data: with W weak classifiers per stage, a window rejected at stage k reports (k+1)·(9·W+1) cycles after the edge that took `start`, and a face reports NUM_STAGES·(9·W+1) cycles after it. The driver stamps each expected item with the cycle count of its start edge. A monitor samples on the falling clock edge, checks the verdict together with the elapsed cycle count, and flags any `done` that arrives with no expected item pending. Stage thresholds are set to the model's exact stage totals and to those totals plus one, which probes the pass-on-equal boundary, and a second start is injected mid-run.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
    localparam int OFF_W  = 5;   // offset / size field width inside a window
    localparam int FTHR_W = 16;  // weak feature threshold width
    localparam int VOTE_W = 12;  // vote value width
    localparam int SUM_W  = 16;  // stage accumulator / stage threshold width

    typedef struct packed {
        logic [OFF_W-1:0] x;
        logic [OFF_W-1:0] y;
        logic [OFF_W-1:0] w;
        logic [OFF_W-1:0] h;
    } rect_t;

    typedef struct packed {
        logic                      last;
        rect_t                     light;
        rect_t                     dark;
        logic signed [FTHR_W-1:0]  thr;
        logic signed [VOTE_W-1:0]  vote_lo;
        logic signed [VOTE_W-1:0]  vote_hi;
    } weak_t;

    localparam int WEAK_BITS = $bits(weak_t);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FEAT,
        PH_VOTE,
        PH_CHECK
    } phase_t;

    // corner[2] selects the dark rectangle, corner[1:0] the corner point
    function automatic logic corner_negative(input logic [2:0] corner);
        return corner[0] ^ corner[1] ^ corner[2];
    endfunction
endpackage

// File: rtl/cascade_corner_addr.sv
module cascade_corner_addr
    import cascade_pkg::*;
#(
    parameter int COORD_W = 9
) (
    input  rect_t              light,
    input  rect_t              dark,
    input  logic [2:0]         corner,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    output logic [COORD_W-1:0] px,
    output logic [COORD_W-1:0] py,
    output logic               neg
);
    rect_t          sel;
    logic [OFF_W:0] dx;
    logic [OFF_W:0] dy;

    always_comb begin
        sel = corner[2] ? dark : light;
        dx  = {1'b0, sel.x} + (corner[0] ? {1'b0, sel.w} : '0);
        dy  = {1'b0, sel.y} + (corner[1] ? {1'b0, sel.h} : '0);
        px  = org_x + COORD_W'(dx);
        py  = org_y + COORD_W'(dy);
        neg = corner_negative(corner);
    end
endmodule

// File: rtl/cascade_weak_vote.sv
module cascade_weak_vote
    import cascade_pkg::*;
#(
    parameter int FEAT_W = 22
) (
    input  logic signed [FEAT_W-1:0] feature,
    input  logic signed [FTHR_W-1:0] thr,
    input  logic signed [VOTE_W-1:0] vote_lo,
    input  logic signed [VOTE_W-1:0] vote_hi,
    output logic signed [VOTE_W-1:0] vote
);
    logic signed [FEAT_W-1:0] thr_ext;

    always_comb begin
        thr_ext = {{(FEAT_W-FTHR_W){thr[FTHR_W-1]}}, thr};
        vote    = (feature < thr_ext) ? vote_lo : vote_hi;
    end
endmodule

// File: rtl/cascade_classifier.sv
module cascade_classifier
    import cascade_pkg::*;
#(
    parameter int NUM_STAGES = 25,
    parameter int COORD_W    = 9,
    parameter int FEAT_AW    = 10,
    parameter int II_W       = 20,
    localparam int STAGE_AW  = $clog2(NUM_STAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [COORD_W-1:0]   win_x,
    input  logic [COORD_W-1:0]   win_y,
    output logic [COORD_W-1:0]   ii_x,
    output logic [COORD_W-1:0]   ii_y,
    input  logic [II_W-1:0]      ii_data,
    output logic [FEAT_AW-1:0]   weak_addr,
    input  logic [WEAK_BITS-1:0] weak_word,
    output logic [STAGE_AW-1:0]  stage_addr,
    input  logic [SUM_W-1:0]     stage_thr,
    output logic                 done,
    output logic                 face
);
    localparam int FEAT_W = II_W + 2;
    localparam logic [STAGE_AW-1:0] LAST_STAGE = STAGE_AW'(NUM_STAGES - 1);

    phase_t                   state_q;
    logic [STAGE_AW-1:0]      stage_q;
    logic [FEAT_AW-1:0]       weak_q;
    logic [2:0]               corner_q;
    logic signed [FEAT_W-1:0] acc_q;
    logic signed [SUM_W-1:0]  sum_q;
    logic [COORD_W-1:0]       org_x_q;
    logic [COORD_W-1:0]       org_y_q;
    logic                     done_q;
    logic                     face_q;

    weak_t                    entry;
    logic                     corner_neg;
    logic signed [FEAT_W-1:0] term;
    logic signed [VOTE_W-1:0] vote;
    logic signed [SUM_W-1:0]  thr_s;

    assign entry      = weak_t'(weak_word);
    assign term       = FEAT_W'(ii_data);
    assign thr_s      = $signed(stage_thr);
    assign weak_addr  = weak_q;
    assign stage_addr = stage_q;
    assign done       = done_q;
    assign face       = face_q;

    cascade_corner_addr #(.COORD_W(COORD_W)) u_corner (
        .light  (entry.light),
        .dark   (entry.dark),
        .corner (corner_q),
        .org_x  (org_x_q),
        .org_y  (org_y_q),
        .px     (ii_x),
        .py     (ii_y),
        .neg    (corner_neg)
    );

    cascade_weak_vote #(.FEAT_W(FEAT_W)) u_vote (
        .feature (acc_q),
        .thr     (entry.thr),
        .vote_lo (entry.vote_lo),
        .vote_hi (entry.vote_hi),
        .vote    (vote)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PH_IDLE;
            stage_q  <= '0;
            weak_q   <= '0;
            corner_q <= '0;
            acc_q    <= '0;
            sum_q    <= '0;
            org_x_q  <= '0;
            org_y_q  <= '0;
            done_q   <= 1'b0;
            face_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            face_q <= 1'b0;
            unique case (state_q)
                PH_IDLE: begin
                    if (start) begin
                        org_x_q  <= win_x;
                        org_y_q  <= win_y;
                        stage_q  <= '0;
                        weak_q   <= '0;
                        corner_q <= '0;
                        acc_q    <= '0;
                        sum_q    <= '0;
                        state_q  <= PH_FEAT;
                    end
                end
                PH_FEAT: begin
                    acc_q    <= corner_neg ? acc_q - term : acc_q + term;
                    corner_q <= corner_q + 3'd1;
                    if (corner_q == 3'd7) state_q <= PH_VOTE;
                end
                PH_VOTE: begin
                    sum_q    <= sum_q + SUM_W'(vote);
                    acc_q    <= '0;
                    weak_q   <= weak_q + 1'b1;
                    state_q  <= entry.last ? PH_CHECK : PH_FEAT;
                end
                PH_CHECK: begin
                    if (sum_q < thr_s) begin
                        done_q  <= 1'b1;
                        state_q <= PH_IDLE;
                    end else if (stage_q == LAST_STAGE) begin
                        done_q  <= 1'b1;
                        face_q  <= 1'b1;
                        state_q <= PH_IDLE;
                    end else begin
                        stage_q <= stage_q + 1'b1;
                        sum_q   <= '0;
                        state_q <= PH_FEAT;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    // R8
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    face_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        face |-> done);

    // R6
    face_after_last_stage_chk: assert property (@(posedge clk) disable iff (rst)
        face |-> $past(stage_q == LAST_STAGE));

    // R7
    done_after_check_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(state_q == PH_CHECK));

    // R2
    stage_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        stage_q <= LAST_STAGE);

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && state_q != PH_IDLE && state_q != PH_CHECK) |=> (weak_q >= $past(weak_q)));
endmodule

// File: tb/cascade_classifier_bench.sv
module cascade_classifier_bench;
    import cascade_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NSTAGE     = 25;
    localparam int WPS        = 2;          // weak classifiers per stage in this bench
    localparam int IMG        = 64;
    localparam int STAGE_LAT  = 9 * WPS + 1;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [8:0]  win_x = '0;
    logic [8:0]  win_y = '0;
    logic [8:0]  ii_x, ii_y;
    logic [19:0] ii_data;
    logic [9:0]  weak_addr;
    logic [WEAK_BITS-1:0] weak_word;
    logic [4:0]  stage_addr;
    logic [SUM_W-1:0] stage_thr;
    logic        done, face;

    int          iimg [0:IMG][0:IMG];
    weak_t       tab  [0:63];
    logic signed [SUM_W-1:0] sthr [0:NSTAGE-1];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic prev_done = 1'b0;

    typedef struct {
        logic  face;
        int    lat;
        int    t0;
        string tag;
    } exp_t;
    exp_t sbq [$];
    exp_t mon_item;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign ii_data   = (ii_x <= 9'(IMG) && ii_y <= 9'(IMG)) ? 20'(iimg[ii_y][ii_x]) : '0;
    assign weak_word = (weak_addr < 10'd64) ? WEAK_BITS'(tab[weak_addr]) : '0;
    assign stage_thr = (stage_addr < 5'(NSTAGE)) ? sthr[stage_addr] : '0;

    cascade_classifier u_cascade_classifier (
        .clk(clk), .rst(rst), .start(start), .win_x(win_x), .win_y(win_y),
        .ii_x(ii_x), .ii_y(ii_y), .ii_data(ii_data),
        .weak_addr(weak_addr), .weak_word(weak_word),
        .stage_addr(stage_addr), .stage_thr(stage_thr),
        .done(done), .face(face)
    );

    function automatic int pix(int x, int y);
        return (x * 7 + y * 13 + ((x * y) % 17) * 5) % 256;
    endfunction

    // R3: direct pixel sum over a rectangle, no integral image involved
    function automatic int rsum(int ox, int oy, rect_t r);
        int s = 0;
        for (int yy = 0; yy < int'(r.h); yy++)
            for (int xx = 0; xx < int'(r.w); xx++)
                s += pix(ox + int'(r.x) + xx, oy + int'(r.y) + yy);
        return s;
    endfunction

    // R4: weak vote; stage total of R5
    function automatic int stage_val(int ox, int oy, int s);
        int total = 0;
        for (int w = 0; w < WPS; w++) begin
            weak_t e = tab[s * WPS + w];
            int feat = rsum(ox, oy, e.light) - rsum(ox, oy, e.dark);
            total += (feat < int'(e.thr)) ? int'(e.vote_lo) : int'(e.vote_hi);
        end
        return total;
    endfunction

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic run_window(int ox, int oy, string tag, int extra_at);
        exp_t it;
        int lat = 0;
        logic fc = 1'b1;
        for (int s = 0; s < NSTAGE; s++) begin
            lat += STAGE_LAT;
            if (stage_val(ox, oy, s) < int'(sthr[s])) begin
                fc = 1'b0;
                break;
            end
        end
        @(negedge clk);
        win_x = 9'(ox);
        win_y = 9'(oy);
        start = 1'b1;
        it.face = fc; it.lat = lat; it.t0 = cyc + 1; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        start = 1'b0;
        if (extra_at > 0) begin
            repeat (extra_at) @(negedge clk);
            win_x = 9'(ox + 3);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (sbq.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R9 unexpected done: actual=1 expected=0");
                end else begin
                    mon_item = sbq.pop_front();
                    checks += 2;
                    if (face !== mon_item.face) begin
                        fails++;
                        $display("FAIL R5/R6 %s face: actual=%0b expected=%0b", mon_item.tag, face, mon_item.face);
                    end
                    if (cyc - mon_item.t0 != mon_item.lat) begin
                        fails++;
                        $display("FAIL R7 %s latency: actual=%0d expected=%0d", mon_item.tag, cyc - mon_item.t0, mon_item.lat);
                    end
                end
                checks++;
                if (prev_done) begin
                    fails++;
                    $display("FAIL R8 done wider than one cycle: actual=1 expected=0");
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=%0d cycles expected<%0d", WATCHDOG, WATCHDOG);
        finish_test();
    end

    initial begin
        // integral image: value at (X,Y) sums pixels with column < X and row < Y (R3)
        for (int y = 0; y <= IMG; y++)
            for (int x = 0; x <= IMG; x++)
                iimg[y][x] = (x == 0 || y == 0) ? 0 :
                             iimg[y-1][x] + iimg[y][x-1] - iimg[y-1][x-1] + pix(x-1, y-1);
        // R2: weak table, two entries per stage, last bit on the second
        for (int f = 0; f < 64; f++) begin
            tab[f].last    = (f % WPS) == WPS - 1;
            tab[f].light.x = 5'(f % 5);
            tab[f].light.y = 5'((f * 3) % 7);
            tab[f].light.w = 5'(4 + f % 3);
            tab[f].light.h = 5'(3 + f % 4);
            tab[f].dark.x  = 5'(f % 5 + 4 + f % 3);
            tab[f].dark.y  = 5'((f * 5) % 6);
            tab[f].dark.w  = 5'(4 + f % 3);
            tab[f].dark.h  = 5'(3 + f % 4);
            tab[f].thr     = 16'((f % 4) * 40 - 60);
            tab[f].vote_lo = 12'(-(10 + f % 5));
            tab[f].vote_hi = 12'(20 + f % 7);
        end
        for (int s = 0; s < NSTAGE; s++) sthr[s] = -16'sd1000;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        checks += 2;
        if (done !== 1'b0) begin fails++; $display("FAIL R1 done after reset: actual=%0b expected=0", done); end
        if (face !== 1'b0) begin fails++; $display("FAIL R1 face after reset: actual=%0b expected=0", face); end

        // R6: all stages pass
        run_window(0, 0, "R6 all pass origin 0,0", 0);
        run_window(17, 9, "R6 all pass origin 17,9", 0);
        // R5: reject at first stage
        sthr[0] = 16'sd1000;
        run_window(4, 4, "R5 reject stage 0", 0);
        sthr[0] = -16'sd1000;
        // R5: reject at final stage
        sthr[NSTAGE-1] = 16'sd1000;
        run_window(8, 20, "R5 reject last stage", 0);
        sthr[NSTAGE-1] = -16'sd1000;
        sthr[7] = 16'sd1000;
        run_window(5, 30, "R5 reject stage 7", 0);
        sthr[7] = -16'sd1000;
        // R5: threshold equal to the total passes, one above fails
        for (int s = 0; s < NSTAGE; s++) sthr[s] = 16'(stage_val(11, 4, s));
        run_window(11, 4, "R5 equal thresholds pass", 0);
        sthr[3] = 16'(stage_val(11, 4, 3) + 1);
        run_window(11, 4, "R5 threshold plus one", 0);
        // R3/R4: data-dependent outcomes
        for (int s = 0; s < NSTAGE; s++) sthr[s] = 16'sd0;
        for (int i = 0; i < 6; i++)
            run_window((i * 7) % 40, (i * 11) % 40, "R4 data dependent", 0);
        // R9: extra start mid-run is ignored
        for (int s = 0; s < NSTAGE; s++) sthr[s] = -16'sd1000;
        run_window(2, 6, "R9 start while busy", 100);
        repeat (40) @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R9 pending results: actual=%0d expected=0", sbq.size());
        end
        finish_test();
    end
endmodule